// File: doc/BRIEF.md
# USB Endpoint Interrupt Request Register (Endpoints 8 to 14)

This block holds the interrupt request bits for the seven upper endpoints, 8 through 14, of a full-speed USB device controller. Each endpoint has a fixed set of status flags that can raise its request bit. The set depends on the endpoint's direction and transfer type:

- IN endpoints use packet-complete and transmit-underrun.
- OUT endpoints use packet-ready and receive-overflow.
- The two isochronous OUT endpoints also use an isochronous error flag, which comes from the frame-number register.

A request bit can only be raised while the endpoint's mask bit is clear. Once raised, the bit holds until software writes a one to it.

Software reads the seven bits through a plain register read port and clears them with write-one-to-clear writes. One combined interrupt line, registered, goes to the system interrupt controller.

Each request bit is a two-state machine:

- `REQ_IDLE`: no request pending. `REQ_PENDING`: request latched.
- Transition `RAISE` (from `REQ_IDLE` to `REQ_PENDING`): a selected source flag is high and the mask bit is clear.
- Transition `ACK` (from `REQ_PENDING` to `REQ_IDLE`): software writes a one to the bit, and no unmasked source flag is high in that cycle.
- In every other case the machine keeps its state.

Top module: `usb_ep_irq_status`

## Requirements
- R1: While an endpoint's mask bit (`ep_mask[k]`, k = endpoint minus 8) is 1, no source flag can set that endpoint's request bit.
- R2: The endpoint 8 and endpoint 13 request bits (slots 0 and 5) are set by `in_done` or `tx_underrun` of that slot. The other flags of those slots have no effect.
- R3: The endpoint 9 and endpoint 14 request bits (slots 1 and 6) are set by `out_ready`, `rx_overflow` or `iso_err` of that slot. The other flags of those slots have no effect.
- R4: The endpoint 10 and endpoint 11 request bits (slots 2 and 3) are set only by `in_done` of that slot.
- R5: The endpoint 12 request bit (slot 4) is set only by `out_ready` of that slot.
- R6: A cycle with `wr_en` high clears every request bit whose `wr_data` bit is 1. Bits written with 0 are unchanged.
- R7: A request bit stays set after its source flags drop, until it is cleared.
- R8: If an unmasked source flag is high in the same cycle as a clearing write, the bit stays set.
- R9: `rd_data` bit k shows the request bit of endpoint 8+k for k = 0..6. Bit 7 always reads 0, and a write to it has no effect.
- R10: `irq` is the OR of the seven request bits, registered. It follows any change of the bits one clock later.
- R11: A synchronous active-high `rst` clears all request bits and `irq`.
- R12: Setting a mask bit does not clear a request bit that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_done | input | 7 | IN packet complete flag per slot (slot k = endpoint 8+k) |
| tx_underrun | input | 7 | Transmit underrun flag per slot |
| out_ready | input | 7 | OUT packet ready flag per slot |
| rx_overflow | input | 7 | Receive overflow flag per slot |
| iso_err | input | 7 | Isochronous error flag per slot, from the frame-number register |
| ep_mask | input | 7 | Per-slot mask; 1 blocks setting |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; a 1 clears the matching bit |
| rd_data | output | 8 | Register read value |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The bench builds the block with its default parameters: seven slots and an eight-bit register. At that size every combination of the five source flags, driven on all slots together, can be crossed with all 128 mask patterns. That sweep covers each slot's source selection and the effect of masking, against a selection table the bench derives from the requirements. Directed sequences then cover:
- partial clear writes and writes to bit 7;
- a clearing write that collides with a raising flag;
- masking a bit that is already pending;
- a reset while bits are pending.

// File: rtl/usb_ep_irq_pkg.sv
package usb_ep_irq_pkg;

    // State of one request bit
    typedef enum logic {
        REQ_IDLE    = 1'b0,
        REQ_PENDING = 1'b1
    } req_state_e;

    // Source vector layout: {iso_err, rx_overflow, out_ready, tx_underrun, in_done}
    localparam int unsigned SRC_W = 5;

    // Which sources can raise the request bit of each slot (slot k = endpoint 8+k)
    function automatic logic [SRC_W-1:0] slot_sources(input int unsigned slot);
        logic [SRC_W-1:0] sel;
        unique case (slot)
            0, 5:    sel = 5'b00011;  // IN bulk/iso: done, underrun
            1, 6:    sel = 5'b11100;  // OUT iso: ready, overflow, iso error
            2, 3:    sel = 5'b00001;  // IN interrupt: done only
            4:       sel = 5'b00100;  // OUT interrupt: ready only
            default: sel = 5'b00000;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/ep_irq_src_sel.sv
module ep_irq_src_sel
    import usb_ep_irq_pkg::*;
#(
    parameter int unsigned SLOT = 0
) (
    input  logic [SRC_W-1:0] flags,
    output logic             evt
);
    localparam logic [SRC_W-1:0] SEL = slot_sources(SLOT);

    assign evt = |(flags & SEL);
endmodule

// File: rtl/ep_irq_req_cell.sv
module ep_irq_req_cell
    import usb_ep_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic mask,
    input  logic clr,
    output logic pend
);
    req_state_e state_q, state_d;
    logic       raise;

    assign raise = evt && !mask;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:    if (raise) state_d = REQ_PENDING;          // RAISE
            REQ_PENDING: if (clr && !raise) state_d = REQ_IDLE;     // ACK
            default:     state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= REQ_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        pend = (state_q == REQ_PENDING);
    end

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!pend && mask) |=> !pend); // R1
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (evt && !mask) |=> pend); // R8
    AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (pend && mask && !clr) |=> pend); // R12
endmodule

// File: rtl/ep_irq_combine.sv
module ep_irq_combine #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |req;
    end

    AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (rst)
        (|req) |=> irq); // R10
    AST_IRQ_LOW: assert property (@(posedge clk) disable iff (rst)
        !(|req) |=> !irq); // R10
endmodule

// File: rtl/usb_ep_irq_status.sv
module usb_ep_irq_status
    import usb_ep_irq_pkg::*;
#(
    parameter int unsigned NUM_EP = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EP-1:0] in_done,
    input  logic [NUM_EP-1:0] tx_underrun,
    input  logic [NUM_EP-1:0] out_ready,
    input  logic [NUM_EP-1:0] rx_overflow,
    input  logic [NUM_EP-1:0] iso_err,
    input  logic [NUM_EP-1:0] ep_mask,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int unsigned PAD_W = DATA_W - NUM_EP;

    logic [NUM_EP-1:0] pend;

    for (genvar s = 0; s < NUM_EP; s++) begin : g_slot
        logic evt;
        logic clr;

        ep_irq_src_sel #(.SLOT(s)) i_sel (
            .flags ({iso_err[s], rx_overflow[s], out_ready[s], tx_underrun[s], in_done[s]}),
            .evt   (evt)
        );

        assign clr = wr_en && wr_data[s];

        ep_irq_req_cell i_cell (
            .clk  (clk),
            .rst  (rst),
            .evt  (evt),
            .mask (ep_mask[s]),
            .clr  (clr),
            .pend (pend[s])
        );
    end

    // Bits above the request bits are not written and read back as zero
    assign rd_data = {{PAD_W{1'b0}}, pend};

    ep_irq_combine #(.N(NUM_EP)) i_comb (
        .clk (clk),
        .rst (rst),
        .req (pend),
        .irq (irq)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && !irq)); // R11
endmodule

// File: tb/test_usb_ep_irq_status.sv
module test_usb_ep_irq_status;
    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] in_done, tx_underrun, out_ready, rx_overflow, iso_err, ep_mask;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       irq;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  finished = 0;

    always #2 clk = ~clk;

    usb_ep_irq_status i_usb_ep_irq_status (
        .clk, .rst, .in_done, .tx_underrun, .out_ready, .rx_overflow,
        .iso_err, .ep_mask, .wr_en, .wr_data, .rd_data, .irq
    );

    // Source selection per slot, taken from R2..R5.
    // Combo bits: 0 done, 1 underrun, 2 ready, 3 overflow, 4 iso error.
    function automatic logic [4:0] exp_sel(input int s);
        case (s)
            0, 5:    return 5'b00011; // R2
            1, 6:    return 5'b11100; // R3
            2, 3:    return 5'b00001; // R4
            default: return 5'b00100; // R5
        endcase
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_flags(input logic [4:0] c);
        in_done     = {7{c[0]}};
        tx_underrun = {7{c[1]}};
        out_ready   = {7{c[2]}};
        rx_overflow = {7{c[3]}};
        iso_err     = {7{c[4]}};
    endtask

    task automatic clear_all;
        wr_en = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; ep_mask = '0;
        set_flags(5'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check8("R11 reset rd", rd_data, 8'h00);
        check8("R11 reset irq", {7'b0, irq}, 8'h00);

        // Exhaustive sweep: all flag combos on all slots x all mask patterns
        for (int c = 0; c < 32; c++) begin
            for (int m = 0; m < 128; m++) begin
                logic [7:0] exp;
                exp = '0;
                for (int s = 0; s < 7; s++)
                    exp[s] = !m[s] && |(c[4:0] & exp_sel(s)); // R1..R5
                ep_mask = m[6:0];
                set_flags(c[4:0]);
                @(negedge clk);
                set_flags(5'b0);
                check8("R1-5 sweep set", rd_data, exp);
                @(negedge clk);
                check8("R7 sticky", rd_data, exp);
                check8("R10 irq", {7'b0, irq}, {7'b0, |exp});
                clear_all;
                check8("R6 clear all", rd_data, 8'h00);
                check8("R10 irq clear", {7'b0, irq}, 8'h00);
            end
        end

        // R6: partial clear and zero write
        ep_mask = '0;
        set_flags(5'b11111);
        @(negedge clk);
        set_flags(5'b0);
        check8("R6 all set", rd_data, 8'h7F);
        wr_en = 1'b1; wr_data = 8'h55;
        @(negedge clk);
        wr_en = 1'b0;
        check8("R6 partial clear", rd_data, 8'h2A);
        wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        check8("R6 zero write", rd_data, 8'h2A);

        // R9: bit 7 write has no effect
        wr_en = 1'b1; wr_data = 8'h80;
        @(negedge clk);
        wr_en = 1'b0;
        check8("R9 bit7", rd_data, 8'h2A);

        // R8: set wins over clear in same cycle (slot 1, out_ready)
        out_ready = 7'b0000010;
        wr_en = 1'b1; wr_data = 8'h02;
        @(negedge clk);
        wr_en = 1'b0; out_ready = '0;
        check8("R8 set wins", rd_data, 8'h2A);
        in_done = 7'b0000001;
        wr_en = 1'b1; wr_data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; in_done = '0;
        check8("R8 set wins idle", rd_data, 8'h2B);

        // R12: masking keeps pending bits
        ep_mask = 7'h7F;
        @(negedge clk);
        @(negedge clk);
        check8("R12 mask keeps", rd_data, 8'h2B);
        ep_mask = '0;

        // R11: reset mid-operation
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check8("R11 reset rd", rd_data, 8'h00);
        check8("R11 reset irq", {7'b0, irq}, 8'h00);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule